// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Word Generator

This block produces a serial test bit stream from a single 32-stage shift register with one XOR gate in its feedback path. It has two modes. In pseudo-random mode the XOR combines the stage picked by a 5-bit length field with the stage picked by a 5-bit tap field, and the result enters stage 0. In repetitive mode the XOR is bypassed and the selected stage feeds stage 0 directly. The register then becomes a recirculating loop of length+1 stages that replays a loaded word without end.

A 32-bit load word with a load strobe presets the register. The register advances only on cycles where the bit enable is high, and an inversion control flips every emitted bit. A small controller holds the block quiet until the first load. It then follows the mode input one cycle behind, so a mode change applies from the cycle after it is presented. The controller has three states. ST_IDLE is entered at reset and left only by a load. ST_PRBS runs the XOR feedback. ST_LOOP runs the plain recirculation. Its transitions are:
- T_ARM_PRBS: ST_IDLE to ST_PRBS, on a load with the mode low.
- T_ARM_LOOP: ST_IDLE to ST_LOOP, on a load with the mode high.
- T_TO_LOOP: ST_PRBS to ST_LOOP, when the mode is high.
- T_TO_PRBS: ST_LOOP to ST_PRBS, when the mode is low.
- T_STAY: any running state stays where it is when the mode matches it.

The phase of the pattern relative to any framing is not defined. Placing the bits into a framed stream and decoding a register bus are left to the surrounding logic.

Top module: `prbs_rep_gen`

## Requirements
- R1: After reset the controller is in ST_IDLE with all stages at one. `bit_o` and `bit_vld_o` are 0, and `bit_en_i` has no effect until the first load.
- R2: When `load_i` is high, the register takes `load_word_i` at the next edge (bit i into stage i), whatever `bit_en_i` is. The controller then enters ST_LOOP if `rep_mode_i` is 1, otherwise ST_PRBS.
- R3: In ST_PRBS, an enabled cycle shifts stage i into stage i+1, and stage 0 receives stage[`len_i`] XOR stage[`tap_i`].
- R4: In ST_PRBS with `len_i`=2 and `tap_i`=0, starting from all ones, the emitted stream repeats every 7 bits and has four ones in each period.
- R5: In ST_LOOP, stage 0 receives stage[`len_i`] with no XOR. The emitted sequence is load-word bits `len_i` down to 0, repeated, which is a period of N = `len_i`+1.
- R6: A load made with `rep_mode_i`=0 whose bits 0..`len_i` are all zero presets every stage to one instead.
- R7: On a cycle with `bit_en_i` low and no load, the register and `bit_o` hold their values.
- R8: In ST_PRBS, an enabled cycle that finds stages 0..`len_i` all zero sets every stage to one instead of shifting.
- R9: Outside ST_IDLE, `bit_o` equals stage[`len_i`] XOR `invert_i`. `bit_vld_o` equals `bit_en_i` in the running states.
- R10: A change of `rep_mode_i` while running takes effect from the cycle after it is presented, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_i | input | 5 | Output stage select; loop length minus one |
| tap_i | input | 5 | Second XOR input stage in pseudo-random mode |
| rep_mode_i | input | 1 | 1 = repetitive loop, 0 = pseudo-random |
| load_word_i | input | 32 | Preset value for the register |
| load_i | input | 1 | Load strobe |
| bit_en_i | input | 1 | Advance the register this cycle |
| invert_i | input | 1 | Invert emitted bits |
| bit_o | output | 1 | Emitted test bit |
| bit_vld_o | output | 1 | `bit_o` is a new bit this cycle |

## Verification
The bench covers these corner cases:
- A loaded 7-bit PRBS. A wrong XOR pair or stage order breaks its period or its count of ones.
- An 8-bit loop word. An off-by-one loop length rotates the word at the wrong period.
- A zero preset in pseudo-random mode. Without the guard this locks the output at zero.
- A zero loop turned into pseudo-random mode while running. This exercises the runtime reseed and the one-cycle lag of the mode change.
- An idle block receiving enables before its first load.
- Long stalls of the enable, and the inversion control.

A random stretch of cycles then checks every output against a behavioural model on every clock.

// File: rtl/prbs_rep_pkg.sv
package prbs_rep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRBS = 2'd1,
        ST_LOOP = 2'd2
    } gen_state_e;

endpackage

// File: rtl/prbs_rep_winchk.sv
module prbs_rep_winchk #(
    parameter int SR_W  = 32,
    parameter int SEL_W = $clog2(SR_W)
) (
    input  logic [SR_W-1:0]  word_i,
    input  logic [SEL_W-1:0] len_i,
    output logic             zero_o
);

    logic [SR_W-1:0] mask;

    for (genvar i = 0; i < SR_W; i++) begin : g_mask
        assign mask[i] = (len_i >= SEL_W'(i));
    end

    assign zero_o = ~|(word_i & mask);

endmodule

// File: rtl/prbs_rep_fb.sv
module prbs_rep_fb #(
    parameter int SR_W  = 32,
    parameter int SEL_W = $clog2(SR_W)
) (
    input  logic [SR_W-1:0]  sr_i,
    input  logic [SEL_W-1:0] len_i,
    input  logic [SEL_W-1:0] tap_i,
    input  logic             loop_i,
    output logic             out_stage_o,
    output logic             fb_o
);

    logic tap_bit;

    always_comb begin
        out_stage_o = sr_i[len_i];
        tap_bit     = sr_i[tap_i];
        fb_o        = loop_i ? out_stage_o : (out_stage_o ^ tap_bit);
    end

endmodule

// File: rtl/prbs_rep_sreg.sv
module prbs_rep_sreg #(
    parameter int SR_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            load_i,
    input  logic            load_fix_i,
    input  logic [SR_W-1:0] load_word_i,
    input  logic            shift_i,
    input  logic            reseed_i,
    input  logic            fb_i,
    output logic [SR_W-1:0] sr_o
);

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q <= '1;
        end else if (load_i) begin
            sr_q <= load_fix_i ? '1 : load_word_i;
        end else if (shift_i) begin
            if (reseed_i) begin
                sr_q <= '1;
            end else begin
                sr_q <= {sr_q[SR_W-2:0], fb_i};
            end
        end
    end

    assign sr_o = sr_q;

    AST_HOLD_IDLE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !shift_i) |=> $stable(sr_q)); // R7
    AST_LOAD_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !load_fix_i) |=> (sr_q == $past(load_word_i))); // R2
    AST_LOAD_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && load_fix_i) |=> (&sr_q)); // R6

endmodule

// File: rtl/prbs_rep_fsm.sv
module prbs_rep_fsm
    import prbs_rep_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       rep_mode_i,
    input  logic       bit_en_i,
    output gen_state_e state_o,
    output logic       shift_o,
    output logic       loop_o,
    output logic       prbs_o
);

    gen_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    state_d = rep_mode_i ? ST_LOOP : ST_PRBS;
                end
            end
            ST_PRBS: begin
                if (rep_mode_i) begin
                    state_d = ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (!rep_mode_i) begin
                    state_d = ST_PRBS;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        shift_o = 1'b0;
        loop_o  = 1'b0;
        prbs_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRBS: begin
                shift_o = bit_en_i;
                prbs_o  = 1'b1;
            end
            ST_LOOP: begin
                shift_o = bit_en_i;
                loop_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_IDLE_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !load_i) |=> (state_q == ST_IDLE)); // R1
    AST_LOAD_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (state_q != ST_IDLE)); // R2
    AST_MODE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE && rep_mode_i) |=> (state_q == ST_LOOP)); // R10

endmodule

// File: rtl/prbs_rep_gen.sv
module prbs_rep_gen
    import prbs_rep_pkg::*;
#(
    parameter int SR_W  = 32,
    parameter int SEL_W = $clog2(SR_W)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] len_i,
    input  logic [SEL_W-1:0] tap_i,
    input  logic             rep_mode_i,
    input  logic [SR_W-1:0]  load_word_i,
    input  logic             load_i,
    input  logic             bit_en_i,
    input  logic             invert_i,
    output logic             bit_o,
    output logic             bit_vld_o
);

    gen_state_e      state;
    logic            shift, loop_sel, prbs_sel;
    logic [SR_W-1:0] sr_q;
    logic            out_stage, fb;
    logic            load_zero, run_zero;
    logic            load_fix, reseed;

    prbs_rep_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .rep_mode_i (rep_mode_i),
        .bit_en_i   (bit_en_i),
        .state_o    (state),
        .shift_o    (shift),
        .loop_o     (loop_sel),
        .prbs_o     (prbs_sel)
    );

    prbs_rep_winchk #(.SR_W(SR_W), .SEL_W(SEL_W)) u_load_chk (
        .word_i (load_word_i),
        .len_i  (len_i),
        .zero_o (load_zero)
    );

    prbs_rep_winchk #(.SR_W(SR_W), .SEL_W(SEL_W)) u_run_chk (
        .word_i (sr_q),
        .len_i  (len_i),
        .zero_o (run_zero)
    );

    prbs_rep_fb #(.SR_W(SR_W), .SEL_W(SEL_W)) u_fb (
        .sr_i        (sr_q),
        .len_i       (len_i),
        .tap_i       (tap_i),
        .loop_i      (loop_sel),
        .out_stage_o (out_stage),
        .fb_o        (fb)
    );

    assign load_fix = load_zero && !rep_mode_i;
    assign reseed   = prbs_sel && run_zero;

    prbs_rep_sreg #(.SR_W(SR_W)) u_sreg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (load_i),
        .load_fix_i  (load_fix),
        .load_word_i (load_word_i),
        .shift_i     (shift),
        .reseed_i    (reseed),
        .fb_i        (fb),
        .sr_o        (sr_q)
    );

    always_comb begin
        if (state == ST_IDLE) begin
            bit_o     = 1'b0;
            bit_vld_o = 1'b0;
        end else begin
            bit_o     = out_stage ^ invert_i;
            bit_vld_o = bit_en_i;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE) |-> (!bit_o && !bit_vld_o)); // R1
    AST_PRBS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift && prbs_sel && !load_i && !run_zero)
        |=> (sr_q[0] == ($past(sr_q[len_i]) ^ $past(sr_q[tap_i])))); // R3
    AST_LOOP_RECIRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift && loop_sel && !load_i) |=> (sr_q[0] == $past(sr_q[len_i]))); // R5
    AST_NO_LOCKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift && prbs_sel && !load_i && run_zero) |=> (&sr_q)); // R8

endmodule

// File: tb/prbs_rep_gen_tb.sv
module prbs_rep_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  len, tap;
    logic        mode, load, en, inv;
    logic [31:0] word;
    logic        bit_o, vld_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_sr;
    int          m_st;
    logic        col_q[$];

    always #10 clk = ~clk;

    prbs_rep_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .len_i(len), .tap_i(tap),
        .rep_mode_i(mode), .load_word_i(word), .load_i(load),
        .bit_en_i(en), .invert_i(inv), .bit_o(bit_o), .bit_vld_o(vld_o)
    );

    function automatic bit win_zero(logic [31:0] w, int l);
        for (int k = 0; k <= l; k++) if (w[k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one clock: inputs already driven at negedge; compare, then advance model
    task automatic cyc(string req);
        logic eb, ev, f;
        #1;
        ev = (m_st != 0) && en;
        eb = (m_st != 0) && (m_sr[len] ^ inv);
        chk(req, vld_o, ev, "bit_vld_o");
        chk(req, bit_o, eb, "bit_o");
        if (vld_o) col_q.push_back(bit_o);
        if (load) begin
            m_sr = (!mode && win_zero(word, int'(len))) ? '1 : word;
            m_st = mode ? 2 : 1;
        end else begin
            if (m_st != 0 && en) begin
                if (m_st == 1 && win_zero(m_sr, int'(len))) m_sr = '1;
                else begin
                    f = (m_st == 2) ? m_sr[len] : (m_sr[len] ^ m_sr[tap]);
                    m_sr = {m_sr[30:0], f};
                end
            end
            if (m_st != 0) m_st = mode ? 2 : 1;
        end
        @(negedge clk);
    endtask

    task automatic drive(logic [4:0] l, logic [4:0] t, logic md, logic ld,
                         logic [31:0] w, logic e, logic iv);
        len = l; tap = t; mode = md; load = ld; word = w; en = e; inv = iv;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ones;
        logic seq[$];
        logic exp8 [8] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
        m_sr = '1; m_st = 0;
        rst_n = 1'b0;
        drive(5'd0, 5'd0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", vld_o, 1'b0, "vld in reset");
        chk("R1", bit_o, 1'b0, "bit in reset");
        rst_n = 1'b1;
        drive(5'd3, 5'd1, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
        repeat (4) cyc("R1");

        // R4: PRBS 2^3-1 from all ones
        drive(5'd2, 5'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cyc("R2");
        load = 1'b0;
        col_q.delete();
        repeat (14) cyc("R4");
        seq = col_q;
        chk("R4", seq.size() == 14, 1'b1, "14 bits collected");
        ones = 0;
        for (int k = 0; k < 7; k++) begin
            if (seq[k]) ones++;
            chk("R4", seq[k+7], seq[k], "period 7");
        end
        chk("R4", ones == 4, 1'b1, "four ones per period");

        // R5: 8-bit loop word 0xA5 emitted msb first
        drive(5'd7, 5'd3, 1'b1, 1'b1, 32'h1234_56A5, 1'b1, 1'b0);
        cyc("R2");
        load = 1'b0;
        col_q.delete();
        repeat (16) cyc("R5");
        seq = col_q;
        for (int k = 0; k < 16; k++) chk("R5", seq[k], exp8[k % 8], "loop bit");

        // R7: enable low holds
        en = 1'b0;
        #1;
        begin
            logic held;
            held = bit_o;
            repeat (6) cyc("R7");
            #1;
            chk("R7", bit_o, held, "bit held while stalled");
        end

        // R9: inversion
        en = 1'b1; inv = 1'b1;
        repeat (10) cyc("R9");
        inv = 1'b0;

        // R6: zero preset in PRBS mode
        drive(5'd4, 5'd1, 1'b0, 1'b1, 32'hFFFF_FF00 & 32'hFFFF_FFE0, 1'b1, 1'b0);
        cyc("R6");
        load = 1'b0;
        #1;
        chk("R6", bit_o, 1'b1, "first bit after zero preset");
        repeat (20) cyc("R6");

        // R8 / R10: zero loop, then switch to PRBS without reload
        drive(5'd4, 5'd2, 1'b1, 1'b1, 32'h0, 1'b1, 1'b0);
        cyc("R8");
        load = 1'b0;
        repeat (3) cyc("R8");
        #1;
        chk("R8", bit_o, 1'b0, "zero loop emits zero");
        mode = 1'b0;
        cyc("R10");
        cyc("R10");
        #1;
        chk("R8", bit_o, 1'b1, "reseed after switch");
        repeat (10) cyc("R3");
        mode = 1'b1;
        repeat (10) cyc("R10");

        // R3: random stretch
        for (int n = 0; n < 1500; n++) begin
            len  = 5'($urandom_range(1, 31));
            if (n % 50 == 0) tap = 5'($urandom);
            if (n % 300 == 0) mode = 1'($urandom);
            load = ($urandom_range(0, 99) < 3);
            word = $urandom;
            en   = ($urandom_range(0, 3) != 0);
            inv  = ($urandom_range(0, 9) == 0);
            cyc("R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule